// File: doc/BRIEF.md
# Block Address Translation Matcher

This block turns a 32-bit effective address into a physical page address whenever the address falls inside one of a small number of large, software-defined blocks. There are two banks of entries. Instruction fetches look only in the fetch bank, and every other access looks only in the data bank. Each entry is a pair of 32-bit words. The upper word holds the block's effective base, a size mask and two privilege enables. The lower word holds the physical base and a two-bit protection code.

The lookup is combinational from the stored words and reports one of three outcomes: a hit with the merged physical page, a miss, or a protection fault. A miss tells the surrounding logic to fall back to its slower translation path. Software loads the entries one word at a time through a synchronous write port. The write selects the bank, the entry index and the upper or lower word, and it is visible to lookups from the following cycle.

Top module: `bat_xlate`

## Requirements
- R1: After reset every stored word is zero. No entry then qualifies, so each valid lookup reports miss in both banks.
- R2: A lookup with lk_fetch_i=1 searches only the fetch bank, and one with lk_fetch_i=0 searches only the data bank. A write with wr_bank_i=1 targets the fetch bank and one with wr_bank_i=0 targets the data bank. wr_lower_i=1 selects the lower word and wr_lower_i=0 the upper word.
- R3: An entry can match only when address bits 31:28 equal upper-word bits 31:28.
- R4: Upper-word bits 12:2 form a size mask aligned to address bits 27:17. An entry can match only when address bits 27:17, with the masked positions cleared, equal upper-word bits 27:17.
- R5: A supervisor lookup (lk_user_i=0) may use an entry only if upper-word bit 1 is set. A user lookup may use it only if upper-word bit 0 is set. An entry that fails this test is skipped, and the search goes on to the next entry.
- R6: On a hit, phys_o bits 31:28 are lower-word bits 31:28. Bits 27:17 are (address AND mask) OR lower-word bits 27:17. Bits 16:12 are address bits 16:12. Bits 11:0 are zero. On a miss phys_o is zero.
- R7: Lower-word bit 1 set grants read and write. Otherwise lower-word bit 0 set grants read only. With neither bit set, the lookup still hits but rd_ok_o and wr_ok_o are both 0.
- R8: When several entries qualify, the lowest-numbered one supplies phys_o and the rights.
- R9: With lk_valid_i=1, miss_o is 1 exactly when no entry qualifies. prot_fault_o is 1 on a hit that lacks the requested right (write when lk_write_i=1, read otherwise). With lk_valid_i=0, hit_o, miss_o and prot_fault_o are all 0.
- R10: A register write takes effect on lookups from the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_bank_i | input | 1 | 1 = fetch bank, 0 = data bank |
| wr_idx_i | input | IDXW | Entry index for the write |
| wr_lower_i | input | 1 | 1 = lower word, 0 = upper word |
| wr_data_i | input | 32 | Write data |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Effective address |
| lk_fetch_i | input | 1 | Access is an instruction fetch |
| lk_user_i | input | 1 | Access is in user state |
| lk_write_i | input | 1 | Access is a store |
| hit_o | output | 1 | A qualifying entry was found |
| miss_o | output | 1 | No entry qualified |
| phys_o | output | 32 | Translated page address |
| rd_ok_o | output | 1 | Read permitted |
| wr_ok_o | output | 1 | Write permitted |
| prot_fault_o | output | 1 | Hit without the requested right |

## Verification
The bench builds the block with the default of four entries per bank, so every entry index and every pairing of overlapping entries can be reached. It checks priority between entries 0 to 3 and checks that a privilege-disabled low entry yields to a higher one. The directed phase includes masks from zero up to several bits wide, so both the pass-through and the compare paths of the size mask are exercised. A random phase then rewrites words in both banks and reaches the mixed overlaps and protection codes.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PAGE_W = 20;
  localparam int unsigned MID_LO = 17;
  localparam int unsigned MID_W  = 11;

  typedef struct packed {
    logic              match;
    logic [PAGE_W-1:0] page;
    logic              rd;
    logic              wr;
  } bat_res_t;
endpackage

// File: rtl/bat_regs.sv
module bat_regs #(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned IDXW  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic                   bank_i,
  input  logic [IDXW-1:0]        idx_i,
  input  logic                   lower_i,
  input  logic [31:0]            data_i,
  input  logic                   fetch_i,
  output logic [N_ENT-1:0][31:0] upper_o,
  output logic [N_ENT-1:0][31:0] lower_o
);
  for (genvar s = 0; s < 2; s++) begin : g_bank
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      logic [31:0] up_q, lo_q;
      logic sel;
      assign sel = we_i && (bank_i == s[0]) && (idx_i == IDXW'(e));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          up_q <= '0;
          lo_q <= '0;
        end else if (sel) begin
          if (lower_i) lo_q <= data_i;
          else         up_q <= data_i;
        end
      end
    end
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_out
    assign upper_o[e] = fetch_i ? g_bank[1].g_ent[e].up_q : g_bank[0].g_ent[e].up_q;
    assign lower_o[e] = fetch_i ? g_bank[1].g_ent[e].lo_q : g_bank[0].g_ent[e].lo_q;
  end
endmodule

// File: rtl/bat_entry.sv
module bat_entry
  import bat_pkg::*;
(
  input  logic [31:0] addr_i,
  input  logic [31:0] upper_i,
  input  logic [31:0] lower_i,
  input  logic        user_i,
  output bat_res_t    res_o
);
  logic [MID_W-1:0] mask, mid;
  logic tag_ok, priv_ok;
  logic unused_bits;

  assign mask    = upper_i[12:2];
  assign mid     = addr_i[MID_LO +: MID_W];
  assign tag_ok  = (addr_i[31:28] == upper_i[31:28]) &&
                   ((mid & ~mask) == upper_i[MID_LO +: MID_W]);
  assign priv_ok = user_i ? upper_i[0] : upper_i[1];

  assign res_o.match = tag_ok && priv_ok;
  assign res_o.page  = {lower_i[31:28], (mid & mask) | lower_i[MID_LO +: MID_W], addr_i[16:12]};
  assign res_o.rd    = lower_i[1] | lower_i[0];
  assign res_o.wr    = lower_i[1];

  assign unused_bits = ^{upper_i[16:13], lower_i[16:2], addr_i[11:0]};
endmodule

// File: rtl/bat_prio.sv
module bat_prio #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic taken;
  always_comb begin
    gnt_o = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !taken) begin
        gnt_o[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  localparam int unsigned IDXW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_bank_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic            wr_lower_i,
  input  logic [31:0]     wr_data_i,
  input  logic            lk_valid_i,
  input  logic [31:0]     lk_addr_i,
  input  logic            lk_fetch_i,
  input  logic            lk_user_i,
  input  logic            lk_write_i,
  output logic            hit_o,
  output logic            miss_o,
  output logic [31:0]     phys_o,
  output logic            rd_ok_o,
  output logic            wr_ok_o,
  output logic            prot_fault_o
);
  logic [N_ENT-1:0][31:0] upper, lower;
  bat_res_t [N_ENT-1:0]   res;
  logic [N_ENT-1:0]       req, gnt;
  logic [PAGE_W-1:0]      page;
  logic                   sel_rd, sel_wr, any;

  bat_regs #(.N_ENT(N_ENT), .IDXW(IDXW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .bank_i  (wr_bank_i),
    .idx_i   (wr_idx_i),
    .lower_i (wr_lower_i),
    .data_i  (wr_data_i),
    .fetch_i (lk_fetch_i),
    .upper_o (upper),
    .lower_o (lower)
  );

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    bat_entry u_ent (
      .addr_i  (lk_addr_i),
      .upper_i (upper[e]),
      .lower_i (lower[e]),
      .user_i  (lk_user_i),
      .res_o   (res[e])
    );
    assign req[e] = res[e].match;
  end

  bat_prio #(.N(N_ENT)) u_prio (.req_i(req), .gnt_o(gnt));

  // one-hot grant: OR-reduce the granted entry's result
  always_comb begin
    page   = '0;
    sel_rd = 1'b0;
    sel_wr = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      page   = page   | ({PAGE_W{gnt[i]}} & res[i].page);
      sel_rd = sel_rd | (gnt[i] & res[i].rd);
      sel_wr = sel_wr | (gnt[i] & res[i].wr);
    end
  end

  assign any          = |req;
  assign hit_o        = lk_valid_i & any;
  assign miss_o       = lk_valid_i & ~any;
  assign phys_o       = hit_o ? {page, 12'h000} : 32'h0;
  assign rd_ok_o      = hit_o & sel_rd;
  assign wr_ok_o      = hit_o & sel_wr;
  assign prot_fault_o = hit_o & (lk_write_i ? ~sel_wr : ~sel_rd);
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        lk_valid_i,
  input logic [31:0] lk_addr_i,
  input logic        lk_write_i,
  input logic        hit_o,
  input logic        miss_o,
  input logic [31:0] phys_o,
  input logic        rd_ok_o,
  input logic        wr_ok_o,
  input logic        prot_fault_o
);
  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> (hit_o ^ miss_o)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> (!hit_o && !miss_o && !prot_fault_o)); // R9
  AST_FAULT_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (prot_fault_o == (lk_write_i ? !wr_ok_o : !rd_ok_o))); // R9
  AST_WR_NEEDS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_o |-> rd_ok_o); // R7
  AST_NO_RIGHTS_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!rd_ok_o && !wr_ok_o && phys_o == 32'h0)); // R6
  AST_PAGE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (phys_o[16:12] == lk_addr_i[16:12] && phys_o[11:0] == 12'h000)); // R6
endmodule

bind bat_xlate bat_xlate_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lk_valid_i   (lk_valid_i),
  .lk_addr_i    (lk_addr_i),
  .lk_write_i   (lk_write_i),
  .hit_o        (hit_o),
  .miss_o       (miss_o),
  .phys_o       (phys_o),
  .rd_ok_o      (rd_ok_o),
  .wr_ok_o      (wr_ok_o),
  .prot_fault_o (prot_fault_o)
);

// File: tb/sim_bat_xlate.sv
module sim_bat_xlate;
  localparam int NE = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_bank = 0, wr_lower = 0;
  logic [1:0] wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic lk_valid = 0, lk_fetch = 0, lk_user = 0, lk_write = 0;
  logic [31:0] lk_addr = 0;
  logic hit, miss, rd_ok, wr_ok, fault;
  logic [31:0] phys;

  int checks = 0, errors = 0;
  string cur_tag = "R1";
  logic [31:0] mu [2][NE];
  logic [31:0] ml [2][NE];

  always #5 clk = ~clk;

  bat_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_bank_i(wr_bank),
    .wr_idx_i(wr_idx), .wr_lower_i(wr_lower), .wr_data_i(wr_data),
    .lk_valid_i(lk_valid), .lk_addr_i(lk_addr), .lk_fetch_i(lk_fetch),
    .lk_user_i(lk_user), .lk_write_i(lk_write), .hit_o(hit), .miss_o(miss),
    .phys_o(phys), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .prot_fault_o(fault)
  );

  // behavioural reference: first qualifying entry in the selected bank
  function automatic void ref_look(output logic eh, em, er, ew, ef, output logic [31:0] ep);
    int b;
    logic [31:0] up, lo, msk;
    logic found;
    b = lk_fetch ? 1 : 0;
    found = 0; ep = 0; er = 0; ew = 0;
    for (int e = 0; e < NE; e++) begin
      up = mu[b][e]; lo = ml[b][e];
      msk = (up & 32'h0000_1FFC) << 15;
      if (!found && (lk_addr & 32'hF000_0000) == (up & 32'hF000_0000) &&
          ((lk_addr & 32'h0FFE_0000) & ~msk) == (up & 32'h0FFE_0000) &&
          (lk_user ? up[0] : up[1])) begin
        found = 1;
        ep = (lo & 32'hF000_0000) | (lk_addr & 32'h0FFE_0000 & msk) |
             (lo & 32'h0FFE_0000) | (lk_addr & 32'h0001_F000);
        er = lo[1] | lo[0];
        ew = lo[1];
      end
    end
    eh = lk_valid && found;
    em = lk_valid && !found;
    if (!eh) begin ep = 0; er = 0; ew = 0; end
    ef = eh && (lk_write ? !ew : !er);
  endfunction

  task automatic compare();
    logic eh, em, er, ew, ef;
    logic [31:0] ep;
    ref_look(eh, em, er, ew, ef, ep);
    checks++;
    if ({hit, miss, rd_ok, wr_ok, fault} !== {eh, em, er, ew, ef} || phys !== ep) begin
      errors++;
      $display("FAIL %s addr=%h got hit=%b miss=%b rd=%b wr=%b flt=%b phys=%h exp hit=%b miss=%b rd=%b wr=%b flt=%b phys=%h",
               cur_tag, lk_addr, hit, miss, rd_ok, wr_ok, fault, phys, eh, em, er, ew, ef, ep);
    end
  endtask

  always @(negedge clk) begin
    #4;
    if (rst_n) compare();
  end

  task automatic wr(input logic bank, input int idx, input logic lower, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_bank = bank; wr_idx = idx[1:0]; wr_lower = lower; wr_data = d;
    @(posedge clk);
    #1;
    if (lower) ml[bank ? 1 : 0][idx] = d; else mu[bank ? 1 : 0][idx] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input string tag, input logic [31:0] a, input logic f, u, w, v = 1);
    @(negedge clk);
    cur_tag = tag;
    lk_addr = a; lk_fetch = f; lk_user = u; lk_write = w; lk_valid = v;
    @(negedge clk);
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < NE; e++) begin mu[b][e] = 0; ml[b][e] = 0; end
    lk_valid = 1; lk_addr = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #2;
    cur_tag = "R1 in reset";
    compare();
    rst_n = 1;
    look("R1", 32'h0000_0000, 0, 0, 0);
    look("R1", 32'h0000_0000, 1, 1, 0);

    // data entry 0: base 0x1000_0000, 128K, supervisor only, read/write
    wr(0, 0, 0, 32'h1000_0002);
    wr(0, 0, 1, 32'h8000_0002);
    look("R10", 32'h1001_5ABC, 0, 0, 0);
    look("R6", 32'h1001_F123, 0, 0, 1);
    look("R5", 32'h1001_5ABC, 0, 1, 0);
    look("R2", 32'h1001_5ABC, 1, 0, 0);
    look("R3", 32'h3001_5ABC, 0, 0, 0);
    look("R4", 32'h1003_5ABC, 0, 0, 0);

    // fetch entry 1: mask bits 23:17, user only, read only
    wr(1, 1, 0, 32'h2000_0000 | (32'h7F << 2) | 32'h1);
    wr(1, 1, 1, 32'h4000_0001);
    look("R4", 32'h20AB_C123, 1, 1, 0);
    look("R6", 32'h20FE_0000, 1, 1, 0);
    look("R4", 32'h2100_0000, 1, 1, 0);
    look("R9", 32'h20AB_C123, 1, 1, 1);
    look("R7", 32'h20AB_C123, 1, 1, 0);
    look("R2", 32'h20AB_C123, 0, 1, 0);

    // data entry 1: no rights, block 0x5000_0000
    wr(0, 1, 0, 32'h5000_0003);
    wr(0, 1, 1, 32'h9000_0000);
    look("R7", 32'h5000_1000, 0, 0, 0);
    look("R9", 32'h5000_1000, 0, 1, 1);

    // overlap: data entries 2 and 3 both cover 0x6000_0000
    wr(0, 3, 0, 32'h6000_0003);
    wr(0, 3, 1, 32'hA000_0002);
    wr(0, 2, 0, 32'h6000_0001);
    wr(0, 2, 1, 32'hB000_0001);
    look("R8", 32'h6000_3000, 0, 1, 0);
    look("R5", 32'h6000_3000, 0, 0, 1);
    wr(0, 2, 1, 32'hC020_0002);
    look("R2", 32'h6000_3000, 0, 1, 1);
    look("R9", 32'h6000_3000, 0, 1, 0, 0);
    look("R9", 32'h7000_0000, 0, 0, 0);

    // random phase
    cur_tag = "R8";
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        wr($urandom_range(0, 1), $urandom_range(0, NE - 1), $urandom_range(0, 1),
           {3'b000, 1'($urandom_range(0, 1)), 28'($urandom)});
      end else begin
        look("R8", {3'b000, 1'($urandom_range(0, 1)), 28'($urandom)},
             $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 7) != 0);
      end
    end

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule